// File: doc/BRIEF.md
# Write-Channel Width Halving Bridge

This block sits between a manager with a 64-bit write data path and a subordinate with a 32-bit write data path. It carries the write address, write data and write response channels of an AXI4 write, one transaction at a time. When a burst moves four bytes or fewer per beat, the address-channel fields go to the narrow side unchanged. The bridge keeps its own running beat address for the burst. For each beat it picks the 32-bit half of the wide beat where that address lands and moves that half's data and byte strobes together onto the narrow bus.

When a burst moves eight bytes per beat, every wide beat becomes two narrow beats. The lower word goes out first and the upper word second. The narrow address phase then carries a size of four bytes and twice the beat count. Only INCR bursts are handled. The subordinate's single response is returned to the manager once for each transaction.

All three channels use valid/ready handshakes. A valid, once raised, stays high with its payload stable until ready is seen. The bridge applies back-pressure by holding the manager-side ready low, so the manager waits. It accepts a new address only after the previous response has completed. It accepts write data only after the narrow address handshake has finished.

Top module: `wr_downsizer`

## Requirements
- R1: For a burst with size code 0, 1 or 2, the narrow address phase carries the manager's address, length, size and burst fields unchanged.
- R2: For a burst with size code 3, the narrow address phase carries the same address and burst type, size code 2 and length 2*len+1. This is valid for len up to 127.
- R3: For a narrow burst, the beat address starts at the start address aligned down to the beat size and grows by 2^size after each narrow beat. Bit 2 of that address selects the half: 0 takes wide data bits [31:0] with strobes [3:0], and 1 takes bits [63:32] with strobes [7:4].
- R4: For a size-3 burst, each wide beat yields two narrow beats, lower word and strobes [3:0] first, then upper word and strobes [7:4]. The manager-side ready is high only in the cycle when the second narrow beat is taken.
- R5: The narrow WLAST is high only on the final narrow beat of the transaction.
- R6: Exactly one response reaches the manager for each transaction, and it carries the subordinate's response code unchanged.
- R7: After an address is accepted, the manager-side address ready stays low until that transaction's response handshake has completed.
- R8: After reset, the manager-side address ready is high and the narrow address valid, narrow write valid and manager-side response valid are low.
- R9: While the narrow address valid is high and not accepted, it stays high and the narrow address stays unchanged.
- R10: No narrow write beat is offered before the narrow address handshake of its transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Manager address valid |
| s_awready | output | 1 | Manager address ready |
| s_awaddr | input | ADDR_W | Manager start address |
| s_awlen | input | 8 | Manager beat count minus one |
| s_awsize | input | 3 | Manager bytes-per-beat code |
| s_awburst | input | 2 | Manager burst type (INCR only) |
| s_wvalid | input | 1 | Manager write valid |
| s_wready | output | 1 | Manager write ready |
| s_wdata | input | 2*NW | Manager write data |
| s_wstrb | input | 2*NW/8 | Manager byte strobes |
| s_wlast | input | 1 | Manager last beat flag |
| s_bvalid | output | 1 | Response valid to manager |
| s_bready | input | 1 | Manager response ready |
| s_bresp | output | 2 | Response code to manager |
| m_awvalid | output | 1 | Narrow address valid |
| m_awready | input | 1 | Narrow address ready |
| m_awaddr | output | ADDR_W | Narrow start address |
| m_awlen | output | 8 | Narrow beat count minus one |
| m_awsize | output | 3 | Narrow bytes-per-beat code |
| m_awburst | output | 2 | Narrow burst type |
| m_wvalid | output | 1 | Narrow write valid |
| m_wready | input | 1 | Narrow write ready |
| m_wdata | output | NW | Narrow write data |
| m_wstrb | output | NW/8 | Narrow byte strobes |
| m_wlast | output | 1 | Narrow last beat flag |
| m_bvalid | input | 1 | Subordinate response valid |
| m_bready | output | 1 | Response ready to subordinate |
| m_bresp | input | 2 | Subordinate response code |

## Verification
The assertions assume the manager holds each valid and its payload until ready. They also assume the manager sends its write beats only after its address handshake, and that a full-width burst never asks for more than 128 beats. The stimulus meets all three assumptions. It raises each valid, holds it until it sees the handshake at the falling edge, and drives write beats only after the address is accepted. It picks full-width lengths below 16, with strobes confined to the lanes that each beat address permits.

// File: rtl/wr_ds_pkg.sv
package wr_ds_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } ds_state_t;
endpackage

// File: rtl/wr_ds_ctrl.sv
module wr_ds_ctrl
  import wr_ds_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WIDE_SIZE = 3,
  parameter int NARR_SIZE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [7:0]        s_awlen,
  input  logic [2:0]        s_awsize,
  input  logic [1:0]        s_awburst,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  input  logic              last_fire,
  output logic              in_data,
  output logic              wide,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp
);
  ds_state_t         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        len_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic              wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
      wide_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (s_awvalid) begin
          addr_q  <= s_awaddr;
          len_q   <= s_awlen;
          size_q  <= s_awsize;
          burst_q <= s_awburst;
          wide_q  <= (s_awsize == 3'(WIDE_SIZE));
          state_q <= ST_ADDR;
        end
        ST_ADDR: if (m_awready) state_q <= ST_DATA;
        ST_DATA: if (last_fire) state_q <= ST_RESP;
        ST_RESP: if (m_bvalid && s_bready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    s_awready = (state_q == ST_IDLE);
    m_awvalid = (state_q == ST_ADDR);
    m_awaddr  = addr_q;
    m_awburst = burst_q;
    m_awlen   = wide_q ? {len_q[6:0], 1'b1} : len_q;
    m_awsize  = wide_q ? 3'(NARR_SIZE) : size_q;
    in_data   = (state_q == ST_DATA);
    wide      = wide_q;
    s_bvalid  = (state_q == ST_RESP) && m_bvalid;
    m_bready  = (state_q == ST_RESP) && s_bready;
    s_bresp   = m_bresp;
  end
endmodule

// File: rtl/wr_ds_beat_track.sv
module wr_ds_beat_track #(
  parameter int ADDR_W   = 32,
  parameter int HALF_BIT = 2,
  parameter int WIDE_SIZE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        start_size,
  input  logic              wide,
  input  logic [7:0]        narrow_len,
  input  logic              beat_fire,
  output logic              half_sel,
  output logic              last_beat,
  output logic              wide_beat_done
);
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;
  logic              phase_q;
  logic [8:0]        cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= '0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load) begin
      addr_q  <= start_addr & ~((ADDR_W'(1) << start_size) - ADDR_W'(1));
      size_q  <= start_size;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (beat_fire) begin
      cnt_q <= cnt_q + 9'd1;
      if (wide) phase_q <= ~phase_q;
      else      addr_q  <= addr_q + (ADDR_W'(1) << size_q);
    end
  end

  assign half_sel       = wide ? phase_q : addr_q[HALF_BIT];
  assign last_beat      = (cnt_q == {1'b0, narrow_len});
  assign wide_beat_done = wide ? phase_q : 1'b1;
endmodule

// File: rtl/wr_ds_lane_mux.sv
module wr_ds_lane_mux #(
  parameter int NW = 32
) (
  input  logic [2*NW-1:0]   wide_data,
  input  logic [2*NW/8-1:0] wide_strb,
  input  logic              half_sel,
  output logic [NW-1:0]     narrow_data,
  output logic [NW/8-1:0]   narrow_strb
);
  localparam int NB = NW / 8;
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign narrow_data[8*b +: 8] = half_sel ? wide_data[NW + 8*b +: 8] : wide_data[8*b +: 8];
    assign narrow_strb[b]        = half_sel ? wide_strb[NB + b]        : wide_strb[b];
  end
endmodule

// File: rtl/wr_downsizer.sv
module wr_downsizer #(
  parameter int ADDR_W = 32,
  parameter int NW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [7:0]        s_awlen,
  input  logic [2:0]        s_awsize,
  input  logic [1:0]        s_awburst,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [2*NW-1:0]   s_wdata,
  input  logic [2*NW/8-1:0] s_wstrb,
  input  logic              s_wlast,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [NW-1:0]     m_wdata,
  output logic [NW/8-1:0]   m_wstrb,
  output logic              m_wlast,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp
);
  localparam int NARR_SIZE = $clog2(NW / 8);
  localparam int WIDE_SIZE = NARR_SIZE + 1;
  localparam int HALF_BIT  = NARR_SIZE;

  logic in_data, wide, half_sel, last_beat, wide_beat_done, beat_fire;
  logic unused_wlast;

  assign unused_wlast = s_wlast;
  assign beat_fire    = m_wvalid && m_wready;

  wr_ds_ctrl #(.ADDR_W(ADDR_W), .WIDE_SIZE(WIDE_SIZE), .NARR_SIZE(NARR_SIZE)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_awlen(s_awlen), .s_awsize(s_awsize), .s_awburst(s_awburst),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .last_fire(beat_fire && last_beat), .in_data(in_data), .wide(wide),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
  );

  wr_ds_beat_track #(.ADDR_W(ADDR_W), .HALF_BIT(HALF_BIT), .WIDE_SIZE(WIDE_SIZE)) i_track (
    .clk(clk), .rst_n(rst_n),
    .load(s_awvalid && s_awready), .start_addr(s_awaddr), .start_size(s_awsize),
    .wide(wide), .narrow_len(m_awlen), .beat_fire(beat_fire),
    .half_sel(half_sel), .last_beat(last_beat), .wide_beat_done(wide_beat_done)
  );

  wr_ds_lane_mux #(.NW(NW)) i_mux (
    .wide_data(s_wdata), .wide_strb(s_wstrb), .half_sel(half_sel),
    .narrow_data(m_wdata), .narrow_strb(m_wstrb)
  );

  assign m_wvalid = in_data && s_wvalid;
  assign m_wlast  = last_beat;
  assign s_wready = in_data && m_wready && wide_beat_done;
endmodule

// File: rtl/wr_ds_checker.sv
module wr_ds_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              s_wvalid,
  input logic              s_wready,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_wlast
);
  assert_aw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));

  assert_single_txn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_awvalid && s_awready |=> !s_awready);

  assert_no_aw_during_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> !s_awready);

  assert_wide_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s_wvalid && s_wready |-> m_wvalid && m_wready);

  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && m_wready && m_wlast |=> !m_wvalid);

  assert_w_after_aw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> !m_wvalid);

  assert_one_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && s_bready |=> !s_bvalid);
endmodule

bind wr_downsizer wr_ds_checker #(.ADDR_W(ADDR_W)) i_checker (
  .clk(clk), .rst_n(rst_n),
  .s_awvalid(s_awvalid), .s_awready(s_awready),
  .s_wvalid(s_wvalid), .s_wready(s_wready),
  .s_bvalid(s_bvalid), .s_bready(s_bready),
  .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
  .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wlast(m_wlast)
);

// File: tb/test_wr_downsizer.sv
module test_wr_downsizer;
  localparam int ADDR_W = 32;
  localparam int NW     = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_awvalid = 0, s_awready;
  logic [ADDR_W-1:0] s_awaddr = '0;
  logic [7:0] s_awlen = '0;
  logic [2:0] s_awsize = '0;
  logic [1:0] s_awburst = 2'd1;
  logic s_wvalid = 0, s_wready;
  logic [63:0] s_wdata = '0;
  logic [7:0] s_wstrb = '0;
  logic s_wlast = 0;
  logic s_bvalid, s_bready = 0;
  logic [1:0] s_bresp;
  logic m_awvalid, m_awready = 0;
  logic [ADDR_W-1:0] m_awaddr;
  logic [7:0] m_awlen;
  logic [2:0] m_awsize;
  logic [1:0] m_awburst;
  logic m_wvalid, m_wready = 0;
  logic [31:0] m_wdata;
  logic [3:0] m_wstrb;
  logic m_wlast;
  logic m_bvalid = 0, m_bready;
  logic [1:0] m_bresp = '0;

  int checks = 0;
  int fails  = 0;

  logic [31:0] exp_d[$];
  logic [3:0]  exp_s[$];
  logic [31:0] got_d[$];
  logic [3:0]  got_s[$];
  logic        got_l[$];
  logic [ADDR_W-1:0] got_addr;
  logic [7:0]  got_len;
  logic [2:0]  got_size;
  logic [1:0]  got_burst;
  logic        w_early;

  always #4 clk = ~clk;

  wr_downsizer #(.ADDR_W(ADDR_W), .NW(NW)) i_wr_downsizer (.*);

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lane_mask(input logic [ADDR_W-1:0] a, input logic [2:0] sz);
    int nb = 1 << sz;
    int lane = int'(a[2:0]) & ~(nb - 1);
    return 8'(((1 << nb) - 1) << lane);
  endfunction

  task automatic mgr_side(input logic [ADDR_W-1:0] addr, input logic [7:0] len,
                          input logic [2:0] sz, input bit full_strb);
    logic hs;
    int nb = 1 << sz;
    logic [ADDR_W-1:0] al = addr & ~ADDR_W'(nb - 1);
    s_awaddr = addr; s_awlen = len; s_awsize = sz; s_awburst = 2'd1; s_awvalid = 1;
    do begin @(negedge clk); hs = s_awready; @(posedge clk); #1; end while (!hs);
    s_awvalid = 0;
    for (int i = 0; i <= int'(len); i++) begin
      logic [ADDR_W-1:0] a = al + ADDR_W'(i * nb);
      logic [7:0] m = lane_mask(a, sz);
      logic [63:0] d = {$urandom, $urandom};
      logic [7:0] st = full_strb ? m : (8'($urandom) & m);
      s_wdata = d; s_wstrb = st; s_wlast = (i == int'(len));
      if (sz == 3'd3) begin
        exp_d.push_back(d[31:0]);  exp_s.push_back(st[3:0]);
        exp_d.push_back(d[63:32]); exp_s.push_back(st[7:4]);
      end else if (a[2]) begin
        exp_d.push_back(d[63:32]); exp_s.push_back(st[7:4]);
      end else begin
        exp_d.push_back(d[31:0]);  exp_s.push_back(st[3:0]);
      end
      s_wvalid = 1;
      do begin @(negedge clk); hs = s_wready; @(posedge clk); #1; end while (!hs);
    end
    s_wvalid = 0; s_wlast = 0;
  endtask

  task automatic sub_side();
    bit aw_seen = 0, done = 0, prev_hold = 0;
    logic [ADDR_W-1:0] prev_addr = '0;
    while (!done) begin
      m_awready = ($urandom % 4) != 0;
      m_wready  = ($urandom % 4) != 0;
      @(negedge clk);
      if (m_wvalid && !aw_seen) w_early = 1;
      if (prev_hold)
        check(m_awvalid && m_awaddr == prev_addr, "R9 held address", longint'(m_awaddr), longint'(prev_addr));
      prev_hold = m_awvalid && !m_awready;
      prev_addr = m_awaddr;
      if (m_awvalid && m_awready) begin
        aw_seen = 1;
        got_addr = m_awaddr; got_len = m_awlen; got_size = m_awsize; got_burst = m_awburst;
      end
      if (m_wvalid && m_wready) begin
        got_d.push_back(m_wdata); got_s.push_back(m_wstrb); got_l.push_back(m_wlast);
        if (m_wlast) done = 1;
      end
      @(posedge clk); #1;
    end
    m_awready = 0; m_wready = 0;
  endtask

  task automatic run_txn(input logic [ADDR_W-1:0] addr, input logic [7:0] len,
                         input logic [2:0] sz, input bit full_strb);
    logic [7:0] xlen = (sz == 3'd3) ? 8'(2 * int'(len) + 1) : len;
    logic [2:0] xsize = (sz == 3'd3) ? 3'd2 : sz;
    string tag = (sz == 3'd3) ? "R2" : "R1";
    string dtag = (sz == 3'd3) ? "R4" : "R3";
    logic [1:0] rsp = 2'($urandom);
    logic hs;
    exp_d.delete(); exp_s.delete(); got_d.delete(); got_s.delete(); got_l.delete();
    w_early = 0;
    fork
      mgr_side(addr, len, sz, full_strb);
      sub_side();
    join
    check(got_addr == addr && got_burst == 2'd1, tag, longint'(got_addr), longint'(addr));
    check(got_len == xlen, tag, longint'(got_len), longint'(xlen));
    check(got_size == xsize, tag, longint'(got_size), longint'(xsize));
    check(!w_early, "R10 early beat", longint'(w_early), 0);
    check(got_d.size() == exp_d.size(), "R5 beat count", got_d.size(), exp_d.size());
    for (int i = 0; i < got_d.size() && i < exp_d.size(); i++) begin
      check(got_d[i] == exp_d[i], dtag, longint'(got_d[i]), longint'(exp_d[i]));
      check(got_s[i] == exp_s[i], dtag, longint'(got_s[i]), longint'(exp_s[i]));
      check(got_l[i] == (i == got_d.size() - 1), "R5 wlast", longint'(got_l[i]), 0);
    end
    m_bresp = rsp; m_bvalid = 1;
    do begin
      s_bready = ($urandom % 2) != 0;
      @(negedge clk);
      check(!s_awready, "R7 aw ready low", longint'(s_awready), 0);
      if (s_bvalid) check(s_bresp == rsp, "R6 bresp", longint'(s_bresp), longint'(rsp));
      hs = s_bvalid && s_bready;
      @(posedge clk); #1;
    end while (!hs);
    m_bvalid = 0; s_bready = 0;
    @(negedge clk);
    check(!s_bvalid && s_awready, "R6 single response", longint'(s_bvalid), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(s_awready && !m_awvalid && !m_wvalid && !s_bvalid, "R8 reset state",
          longint'({s_awready, m_awvalid, m_wvalid, s_bvalid}), 64'h8);
    @(posedge clk); #1;
    // directed: 16-bit beats over one wide word, halves 0,0,1,1 (R3)
    run_txn(32'h0642_0860, 8'd3, 3'd1, 1'b1);
    // directed: full-width single and multi beat splits (R4, R2)
    run_txn(32'h0000_1000, 8'd0, 3'd3, 1'b1);
    run_txn(32'h0000_2008, 8'd3, 3'd3, 1'b1);
    // directed: word beats starting in upper half, bytes from unaligned start
    run_txn(32'h0000_3004, 8'd4, 3'd2, 1'b1);
    run_txn(32'h0000_4003, 8'd9, 3'd0, 1'b0);
    for (int t = 0; t < 40; t++) begin
      logic [2:0] sz = 3'($urandom % 4);
      logic [7:0] ln = 8'($urandom % 12);
      logic [ADDR_W-1:0] a = ADDR_W'($urandom % 32'h10000) & ~ADDR_W'((1 << sz) - 1);
      run_txn(a, ln, sz, 1'b0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule